// File: doc/BRIEF.md
# Multiplexed-Address DRAM Front End

This block sits between a user port and a two-dimensional storage array whose address pins are half as wide as the full address. The upper half of the address selects a row and the lower half selects a column. Both halves travel over the same shared lines, one after the other. A row strobe marks the cycle that carries the row half, and a column strobe marks the cycle that carries the column half. The array latches the row on the row strobe. On the column strobe it reads the addressed word or writes it.

Requests enter through a ready/valid handshake. Each accepted request takes four phases of one clock each, and ready stays low until the sequence is over. The states are named as follows:

- `ST_IDLE`: waiting.
- `ST_ROW`: row strobe.
- `ST_COL`: column strobe, with the write enable for stores.
- `ST_PRE`: precharge, where read data is returned.
- `ST_IDLE` again.

A refresh scheduler raises a request every `cfg_refresh_gap` clocks. While that request is pending, ready is low. Once the sequencer reaches `ST_IDLE`, it runs a refresh through `ST_REF_ROW` and then `ST_REF_PRE`. `ST_REF_ROW` drives only the row strobe, carrying the refresh row. `ST_REF_PRE` is an idle precharge clock. The refresh row pointer then advances to the next row, wrapping after the last one.

The state transitions are:

- `ST_IDLE` goes to `ST_REF_ROW` when a refresh is pending.
- `ST_IDLE` goes to `ST_ROW` on an accepted request.
- `ST_ROW` goes to `ST_COL`.
- `ST_COL` goes to `ST_PRE`.
- `ST_PRE` goes to `ST_IDLE`.
- `ST_REF_ROW` goes to `ST_REF_PRE`.
- `ST_REF_PRE` goes to `ST_IDLE`.

The behavioural storage array lives inside the top module.

Top module: `mux_dram_frontend`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1 and bus_row_stb, bus_col_stb, bus_we and rsp_valid are all 0.
- R2: In the cycle after a request is accepted (req_valid and req_ready both 1 at a rising edge), bus_row_stb is 1 and bus_addr equals req_addr[2N-1:N]. In the following cycle bus_col_stb is 1, bus_row_stb is 0 and bus_addr equals req_addr[N-1:0]. The two strobes are never 1 together.
- R3: After the column cycle there is one precharge cycle with both strobes at 0. req_ready is 0 from the row cycle through the precharge cycle. If no refresh is pending, req_ready returns to 1 four cycles after the accepting edge.
- R4: bus_we is 1 during the column cycle when req_write was 1 at acceptance, and 0 otherwise. A write stores req_wdata at the addressed row and column.
- R5: For a read (req_write = 0), rsp_valid is 1 for exactly the precharge cycle, and rsp_rdata then holds the last value written to that address.
- R6: Counting the first rising edge after reset release as edge 1, a refresh request is raised at edge cfg_refresh_gap and every cfg_refresh_gap edges after that. With no user traffic, the first refresh row strobe appears in the cycle after edge cfg_refresh_gap+1, with bus_addr = 0.
- R7: While a refresh request is pending, req_ready is 0. A pending refresh is carried out before any further request is accepted.
- R8: A refresh is one cycle with bus_row_stb = 1 and bus_addr = the refresh row, followed by one cycle with both strobes at 0. The column strobe never fires during a refresh. Stored data is unchanged by refreshes.
- R9: Refresh rows follow the order 0, 1, …, 2^N-1 and then wrap to 0. Two consecutive refresh row strobes are at most cfg_refresh_gap+4 cycles apart, so every row is refreshed within one full refresh period.
- R10: A request with req_valid held at 1 while req_ready is 0 is not started. It is accepted at the first rising edge where req_ready is 1, and its row cycle follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_refresh_gap | input | GAP_W | Clocks between refresh requests (at least 8 in use) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Front end can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*HALF_W | Full address: row in upper half, column in lower half |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid (precharge cycle of a read) |
| rsp_rdata | output | DATA_W | Read data |
| bus_addr | output | HALF_W | Shared row/column address lines |
| bus_row_stb | output | 1 | Row strobe |
| bus_col_stb | output | 1 | Column strobe |
| bus_we | output | 1 | Write enable, meaningful with the column strobe |

## Verification
All timing is counted from the accepting rising edge, and every check samples on the falling edge of the intended cycle. The row half is due in the first cycle after that edge, the column half and write enable in the second, and read data with rsp_valid in the third. Refresh timing is counted in edges from reset release: the request raises ready-low after edge gap, and the refresh row strobe follows after edge gap+1. A falling-edge monitor then classifies every row strobe not followed by a column strobe as a refresh. For each one it checks the row order and the cycle gap since the previous refresh, and read-backs after long idle stretches confirm the data survived.

// File: rtl/dram_fe_pkg.sv
package dram_fe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ROW     = 3'd1,
        ST_COL     = 3'd2,
        ST_PRE     = 3'd3,
        ST_REF_ROW = 3'd4,
        ST_REF_PRE = 3'd5
    } fe_state_t;

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int ROW_W = 4,
    parameter int GAP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             done_i,
    output logic             pending_o,
    output logic [ROW_W-1:0] row_o
);

    logic [GAP_W-1:0] cnt_q;
    logic             pending_q;
    logic [ROW_W-1:0] row_q;
    logic             tick;

    // interval expiry; a gap of 0 or 1 requests every cycle
    assign tick = (gap_i <= GAP_W'(1)) || (cnt_q >= gap_i - GAP_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pending_q <= 1'b0;
            row_q     <= '0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + GAP_W'(1);
            if (tick)
                pending_q <= 1'b1;
            else if (done_i)
                pending_q <= 1'b0;
            if (done_i)
                row_q <= row_q + ROW_W'(1);
        end
    end

    assign pending_o = pending_q;
    assign row_o     = row_q;

    // R7: a raised request stays up until the sequencer reports it done
    assert_pending_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !done_i) |=> pending_q)
        else $error("pending refresh dropped before service");

    // R9: each completed refresh moves the row pointer on by one, wrapping
    assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (row_q == $past(row_q) + ROW_W'(1)))
        else $error("refresh row pointer skipped");

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int HALF_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] addr_i,
    input  logic              row_stb_i,
    input  logic              col_stb_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int WORDS = 1 << (2 * HALF_W);

    logic [DATA_W-1:0] cells [WORDS];
    logic [HALF_W-1:0] open_row_q;

    // step one: row latch on row strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_row_q <= '0;
        else if (row_stb_i)
            open_row_q <= addr_i;
    end

    // step two: column access inside the open row
    always_ff @(posedge clk) begin
        if (col_stb_i && we_i)
            cells[{open_row_q, addr_i}] <= wdata_i;
    end

    assign rdata_o = cells[{open_row_q, addr_i}];

    // R2: a column strobe always follows a row strobe in the previous cycle
    assert_col_after_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        col_stb_i |-> $past(row_stb_i))
        else $error("column strobe without preceding row strobe");

endmodule

// File: rtl/dram_fe_seq.sv
module dram_fe_seq
    import dram_fe_pkg::*;
#(
    parameter int HALF_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*HALF_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                ref_pending,
    input  logic [HALF_W-1:0]   ref_row,
    output logic                ref_done,
    input  logic [DATA_W-1:0]   arr_rdata,
    output logic [HALF_W-1:0]   bus_addr,
    output logic                row_stb,
    output logic                col_stb,
    output logic                bus_we,
    output logic [DATA_W-1:0]   bus_wdata
);

    localparam int ADDR_W = 2 * HALF_W;

    fe_state_t         state_q, state_d;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] lat_wdata_q;
    logic              lat_write_q;
    logic [DATA_W-1:0] rsp_q;
    logic              accept;

    assign accept = req_valid && req_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending)
                    state_d = ST_REF_ROW;
                else if (req_valid)
                    state_d = ST_ROW;
            end
            ST_ROW:     state_d = ST_COL;
            ST_COL:     state_d = ST_PRE;
            ST_PRE:     state_d = ST_IDLE;
            ST_REF_ROW: state_d = ST_REF_PRE;
            ST_REF_PRE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lat_addr_q  <= '0;
            lat_wdata_q <= '0;
            lat_write_q <= 1'b0;
            rsp_q       <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lat_addr_q  <= req_addr;
                lat_wdata_q <= req_wdata;
                lat_write_q <= req_write;
            end
            if (state_q == ST_COL && !lat_write_q)
                rsp_q <= arr_rdata;
        end
    end

    // outputs per state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        ref_done  = 1'b0;
        bus_addr  = '0;
        row_stb   = 1'b0;
        col_stb   = 1'b0;
        bus_we    = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = !ref_pending;
            ST_ROW: begin
                row_stb  = 1'b1;
                bus_addr = lat_addr_q[ADDR_W-1:HALF_W];
            end
            ST_COL: begin
                col_stb  = 1'b1;
                bus_we   = lat_write_q;
                bus_addr = lat_addr_q[HALF_W-1:0];
            end
            ST_PRE: rsp_valid = !lat_write_q;
            ST_REF_ROW: begin
                row_stb  = 1'b1;
                bus_addr = ref_row;
            end
            ST_REF_PRE: ref_done = 1'b1;
            default: ;
        endcase
    end

    assign bus_wdata = lat_wdata_q;
    assign rsp_rdata = rsp_q;

    // R2: the two strobes never overlap
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_stb, col_stb}))
        else $error("row and column strobes overlap");

    // R3: an accepted request drives the row strobe next cycle
    assert_accept_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (row_stb && !col_stb))
        else $error("accepted request did not start with row strobe");

    // R7: idle with a refresh pending always goes to the refresh row cycle
    assert_refresh_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ref_pending) |=> (state_q == ST_REF_ROW))
        else $error("pending refresh not taken first");

    // R8: refresh row cycle is followed by a cycle with no strobe at all
    assert_refresh_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REF_ROW) |=> (!col_stb && !row_stb && !bus_we))
        else $error("strobe during refresh precharge");

endmodule

// File: rtl/mux_dram_frontend.sv
module mux_dram_frontend #(
    parameter int HALF_W = 4,
    parameter int DATA_W = 8,
    parameter int GAP_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GAP_W-1:0]    cfg_refresh_gap,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*HALF_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [HALF_W-1:0]   bus_addr,
    output logic                bus_row_stb,
    output logic                bus_col_stb,
    output logic                bus_we
);

    logic              ref_pending;
    logic              ref_done;
    logic [HALF_W-1:0] ref_row;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] bus_wdata;

    dram_refresh_sched #(
        .ROW_W (HALF_W),
        .GAP_W (GAP_W)
    ) sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .gap_i     (cfg_refresh_gap),
        .done_i    (ref_done),
        .pending_o (ref_pending),
        .row_o     (ref_row)
    );

    dram_fe_seq #(
        .HALF_W (HALF_W),
        .DATA_W (DATA_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .ref_pending (ref_pending),
        .ref_row     (ref_row),
        .ref_done    (ref_done),
        .arr_rdata   (arr_rdata),
        .bus_addr    (bus_addr),
        .row_stb     (bus_row_stb),
        .col_stb     (bus_col_stb),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata)
    );

    dram_cell_array #(
        .HALF_W (HALF_W),
        .DATA_W (DATA_W)
    ) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .row_stb_i (bus_row_stb),
        .col_stb_i (bus_col_stb),
        .we_i      (bus_we),
        .wdata_i   (bus_wdata),
        .rdata_o   (arr_rdata)
    );

endmodule

// File: tb/mux_dram_frontend_tb_top.sv
`timescale 1ns/1ps
module mux_dram_frontend_tb_top;

    localparam int HALF_W = 4;
    localparam int DATA_W = 8;
    localparam int GAP_W  = 12;
    localparam int ROWS   = 1 << HALF_W;
    localparam int GAP    = 20;
    localparam int NVEC   = 12;

    // vector: {write, addr[7:0], data[7:0]}; for reads data is the expected value
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 8'hA5}, {1'b1, 8'hFF, 8'h3C}, {1'b1, 8'h0F, 8'h11},
        {1'b1, 8'hF0, 8'h22}, {1'b1, 8'h37, 8'hC8}, {1'b1, 8'h73, 8'h9E},
        {1'b0, 8'h00, 8'hA5}, {1'b0, 8'hFF, 8'h3C}, {1'b0, 8'h0F, 8'h11},
        {1'b0, 8'hF0, 8'h22}, {1'b0, 8'h37, 8'hC8}, {1'b0, 8'h73, 8'h9E}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [GAP_W-1:0]    cfg_refresh_gap = GAP_W'(GAP);
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_write = 1'b0;
    logic [2*HALF_W-1:0] req_addr = '0;
    logic [DATA_W-1:0]   req_wdata = '0;
    logic                rsp_valid;
    logic [DATA_W-1:0]   rsp_rdata;
    logic [HALF_W-1:0]   bus_addr;
    logic                bus_row_stb;
    logic                bus_col_stb;
    logic                bus_we;

    int n_total = 0;
    int n_bad   = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    mux_dram_frontend #(
        .HALF_W (HALF_W),
        .DATA_W (DATA_W),
        .GAP_W  (GAP_W)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_refresh_gap (cfg_refresh_gap),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .rsp_valid       (rsp_valid),
        .rsp_rdata       (rsp_rdata),
        .bus_addr        (bus_addr),
        .bus_row_stb     (bus_row_stb),
        .bus_col_stb     (bus_col_stb),
        .bus_we          (bus_we)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // refresh monitor: a row strobe not followed by a column strobe is a refresh
    bit                mon_en = 1'b0;
    bit                prev_row = 1'b0;
    logic [HALF_W-1:0] prev_addr = '0;
    logic [HALF_W-1:0] exp_ref = '0;
    logic [ROWS-1:0]   seen = '0;
    int                since = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            since++;
            if (prev_row && !bus_col_stb) begin
                chk(prev_addr == exp_ref, "R9 refresh row order", prev_addr, exp_ref);
                chk(since <= GAP + 4, "R9 refresh spacing", since, GAP + 4);
                seen[prev_addr] = 1'b1;
                exp_ref = exp_ref + 1'b1;
                since = 0;
            end
            prev_row  = bus_row_stb;
            prev_addr = bus_addr;
        end
    end

    // one access: wait for ready, then check each phase at the falling edge
    task automatic do_access(input bit wr, input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);   // after accepting edge: row cycle
        req_valid = 1'b0;
        chk(bus_row_stb && !bus_col_stb, "R2 row strobe", bus_row_stb, 1);
        chk(bus_addr == addr[7:4], "R2 row half", bus_addr, addr[7:4]);
        chk(!req_ready, "R3 ready low in row", req_ready, 0);
        chk(!req_ready, "R10 held request accepted once", req_ready, 0);
        @(negedge clk);   // column cycle
        chk(bus_col_stb && !bus_row_stb, "R2 col strobe", bus_col_stb, 1);
        chk(bus_addr == addr[3:0], "R2 col half", bus_addr, addr[3:0]);
        chk(bus_we == wr, "R4 write enable", bus_we, wr);
        @(negedge clk);   // precharge cycle
        chk(!bus_row_stb && !bus_col_stb, "R3 precharge quiet", {bus_row_stb, bus_col_stb}, 0);
        chk(rsp_valid == !wr, "R5 rsp_valid", rsp_valid, !wr);
        if (!wr)
            chk(rsp_rdata == data, "R5 R8 read data", rsp_rdata, data);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(req_ready && !bus_row_stb && !bus_col_stb && !bus_we && !rsp_valid,
            "R1 reset outputs", {req_ready, bus_row_stb, bus_col_stb, bus_we, rsp_valid}, 5'b10000);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);   // after edge 1
        chk(req_ready && !bus_row_stb && !rsp_valid, "R1 first cycle", req_ready, 1);
        repeat (GAP - 2) @(negedge clk);   // after edge GAP-1
        chk(req_ready, "R6 no refresh before gap", req_ready, 1);
        @(negedge clk);   // after edge GAP: refresh pending
        chk(!req_ready, "R6 R7 ready low on pending", req_ready, 0);
        req_valid = 1'b1;  // held while not ready
        req_write = 1'b1;
        req_addr  = 8'h95;
        req_wdata = 8'h5A;
        @(negedge clk);   // after edge GAP+1: refresh row cycle
        chk(bus_row_stb && bus_addr == 0, "R6 R8 refresh row 0", bus_addr, 0);
        chk(!req_ready, "R10 request held off", req_ready, 0);
        @(negedge clk);   // after edge GAP+2: refresh precharge
        chk(!bus_row_stb && !bus_col_stb, "R8 refresh no column strobe", bus_col_stb, 0);
        @(negedge clk);   // after edge GAP+3: idle again
        chk(req_ready, "R3 R7 ready back after refresh", req_ready, 1);
        req_valid = 1'b0;
        do_access(1'b1, 8'h95, 8'h5A);
        do_access(1'b0, 8'h95, 8'h5A);

        // table walk with idle gaps so refreshes interleave
        for (int i = 0; i < NVEC; i++) begin
            do_access(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
            repeat (i % 5) @(negedge clk);
        end

        // R9: full refresh period with no traffic covers every row
        seen = '0;
        repeat (ROWS * (GAP + 4)) @(negedge clk);
        chk(seen == {ROWS{1'b1}}, "R9 all rows refreshed", seen, {ROWS{1'b1}});

        // R8: data survives many refreshes
        for (int i = 0; i < NVEC; i++)
            if (!VEC[i][16])
                do_access(1'b0, VEC[i][15:8], VEC[i][7:0]);
        do_access(1'b0, 8'h95, 8'h5A);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule